// File: doc/BRIEF.md
# Receive Header Acceptance Filter

The block decides, for each received frame header, whether the frame is kept and into which of two receive queues it goes. It holds a set of configurable filter banks. Each bank carries two 32-bit configuration words and four control bits. One bit picks list or mask mode and one picks 32-bit or 16-bit scale. The other two name the target queue and whether the bank is active. From these a bank acts as four exact 16-bit identifiers, two exact 32-bit identifiers, two 16-bit identifier/mask pairs, or one 32-bit identifier/mask pair.

On a header strobe the identifier, the extended flag and the remote flag are packed into a comparison key. The key is matched against every active bank that lies in the controller's assigned bank window. The lowest-index bank that accepts names the queue. The result is registered and appears one clock after the strobe, where it stays until the next strobe. The extended and remote flags are compared like any other key bit, so a bank can require or ignore them. Queue fill state plays no part in the choice.

Top module: `can_accept_filter`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. `res_hit`, `res_fifo` and `res_bank` take their new values at that same edge and then hold until the next strobe.
- R2: The 32-bit key for a base-format frame (`hdr_ide`=0) is `{hdr_id[10:0], 18'b0, 1'b0, hdr_rtr, 1'b0}`. For an extended frame (`hdr_ide`=1) it is `{hdr_id[28:0], 1'b1, hdr_rtr, 1'b0}`. So bit 2 is the extended flag, bit 1 is the remote flag and bit 0 is always zero.
- R3: The 16-bit key is `{key32[31:21], hdr_rtr, hdr_ide, key32[20:18]}`. Its low three bits are extended identifier bits 17:15, or zero for base frames.
- R4: In list mode at 32-bit scale, a bank accepts when the 32-bit key equals word1 or equals word2.
- R5: In mask mode at 32-bit scale, word1 is the identifier and word2 the mask. A bank accepts when (key & word2) == (word1 & word2), so an all-zero mask accepts every frame.
- R6: In list mode at 16-bit scale, the four exact entries are word1[15:0], word1[31:16], word2[15:0] and word2[31:16]. The bank accepts when the 16-bit key equals any of them.
- R7: In mask mode at 16-bit scale, each word is one pair, with the identifier in bits 15:0 and the mask in bits 31:16. The bank accepts when either pair matches the 16-bit key under its mask.
- R8: Per bank, `cfg_list` 1 selects list mode and 0 selects mask mode. `cfg_wide` 1 selects 32-bit scale and 0 selects 16-bit scale.
- R9: Only banks with `cfg_active` set can accept. When no bank accepts, `res_hit` is 0 and both `res_fifo` and `res_bank` are 0.
- R10: When several banks accept, `res_bank` is the lowest accepting index and `res_fifo` is that bank's `cfg_fifo` bit (0 = queue 0, 1 = queue 1).
- R11: Only banks with index in [`range_start`, `range_start`+`range_count`) can accept. Banks outside the window never produce a hit.
- R12: During and right after reset, `res_valid`, `res_hit`, `res_fifo` and `res_bank` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| hdr_id | input | 29 | Identifier; base frames use bits 10:0 |
| hdr_ide | input | 1 | Extended-format flag |
| hdr_rtr | input | 1 | Remote-request flag |
| cfg_word1 | input | NUM_BANKS*32 | First configuration word of each bank, bank b at [b*32 +: 32] |
| cfg_word2 | input | NUM_BANKS*32 | Second configuration word of each bank |
| cfg_list | input | NUM_BANKS | 1 = list mode, 0 = mask mode |
| cfg_wide | input | NUM_BANKS | 1 = 32-bit scale, 0 = 16-bit scale |
| cfg_fifo | input | NUM_BANKS | Target queue of each bank |
| cfg_active | input | NUM_BANKS | Bank takes part in matching |
| range_start | input | CNT_W | First bank of the controller window |
| range_count | input | CNT_W | Number of banks in the window |
| res_valid | output | 1 | Result strobe, one cycle after `hdr_valid` |
| res_hit | output | 1 | Frame accepted |
| res_fifo | output | 1 | Queue chosen by the winning bank |
| res_bank | output | IDX_W | Index of the winning bank |

## Verification
Each bank shape is tried with frames that differ from a configured entry in one field only: the identifier, the remote flag, or the extended flag. This shows that each slot sits where R4 to R7 place it and that the flags are compared as key bits. Extended frames that differ only in identifier bits 17:15 are sent to a 16-bit mask bank. This separates the specified low key bits from zero padding. Overlapping accept-all banks with different queues are then enabled, disabled and moved in and out of the window, which exposes errors in the priority order and in the window edges. Last comes a long run of random configurations and headers, checked against a behavioural model on every clock.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int ID_W   = 29;
  localparam int KEY_W  = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic [KEY_W-1:0]  key32;
    logic [HALF_W-1:0] key16;
  } filt_key_t;

  typedef struct packed {
    logic [KEY_W-1:0] w1;
    logic [KEY_W-1:0] w2;
    logic             list_mode;
    logic             wide;
  } bank_cfg_t;
endpackage

// File: rtl/can_filt_key.sv
module can_filt_key
  import can_filt_pkg::*;
(
  input  logic [ID_W-1:0] id,
  input  logic            ide,
  input  logic            rtr,
  output filt_key_t       key
);
  logic [KEY_W-1:0] k32;

  always_comb begin
    if (ide) begin
      k32 = {id, 1'b1, rtr, 1'b0};
    end else begin
      k32 = {id[10:0], 18'b0, 1'b0, rtr, 1'b0};
    end
    key.key32 = k32;
    key.key16 = {k32[31:21], rtr, ide, k32[20:18]};
  end
endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  filt_key_t key,
  input  bank_cfg_t cfg,
  output logic      match
);
  localparam int N_LIST16 = 4;
  localparam int N_MASK16 = 2;

  logic [2*KEY_W-1:0]      both;
  logic [N_LIST16-1:0]     l16_hit;
  logic [N_MASK16-1:0]     m16_hit;
  logic                    l32_hit;
  logic                    m32_hit;

  assign both = {cfg.w2, cfg.w1};

  genvar s;
  generate
    for (s = 0; s < N_LIST16; s++) begin : g_l16
      assign l16_hit[s] = (key.key16 == both[s*HALF_W +: HALF_W]);
    end
    for (s = 0; s < N_MASK16; s++) begin : g_m16
      logic [HALF_W-1:0] idv;
      logic [HALF_W-1:0] msk;
      assign idv = both[s*KEY_W +: HALF_W];
      assign msk = both[s*KEY_W + HALF_W +: HALF_W];
      assign m16_hit[s] = ((key.key16 & msk) == (idv & msk));
    end
  endgenerate

  assign l32_hit = (key.key32 == cfg.w1) || (key.key32 == cfg.w2);
  assign m32_hit = ((key.key32 & cfg.w2) == (cfg.w1 & cfg.w2));

  always_comb begin
    unique case ({cfg.list_mode, cfg.wide})
      2'b11:   match = l32_hit;
      2'b01:   match = m32_hit;
      2'b10:   match = |l16_hit;
      default: match = |m16_hit;
    endcase
  end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int N     = 28,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int  NUM_BANKS = 28,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  input  logic [ID_W-1:0]            hdr_id,
  input  logic                       hdr_ide,
  input  logic                       hdr_rtr,
  input  logic [NUM_BANKS*KEY_W-1:0] cfg_word1,
  input  logic [NUM_BANKS*KEY_W-1:0] cfg_word2,
  input  logic [NUM_BANKS-1:0]       cfg_list,
  input  logic [NUM_BANKS-1:0]       cfg_wide,
  input  logic [NUM_BANKS-1:0]       cfg_fifo,
  input  logic [NUM_BANKS-1:0]       cfg_active,
  input  logic [CNT_W-1:0]           range_start,
  input  logic [CNT_W-1:0]           range_count,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic                       res_fifo,
  output logic [IDX_W-1:0]           res_bank
);
  filt_key_t              key;
  logic [NUM_BANKS-1:0]   bank_match;
  logic [NUM_BANKS-1:0]   qualified;
  logic [CNT_W:0]         win_lo;
  logic [CNT_W:0]         win_hi;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;

  logic                   valid_d;
  logic                   hit_d;
  logic                   fifo_d;
  logic [IDX_W-1:0]       bank_d;

  can_filt_key u_key (
    .id  (hdr_id),
    .ide (hdr_ide),
    .rtr (hdr_rtr),
    .key (key)
  );

  assign win_lo = {1'b0, range_start};
  assign win_hi = {1'b0, range_start} + {1'b0, range_count};

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [CNT_W:0] BIDX = (CNT_W+1)'(b);
      bank_cfg_t cfg;
      logic      in_win;
      assign cfg.w1        = cfg_word1[b*KEY_W +: KEY_W];
      assign cfg.w2        = cfg_word2[b*KEY_W +: KEY_W];
      assign cfg.list_mode = cfg_list[b];
      assign cfg.wide      = cfg_wide[b];
      assign in_win        = (BIDX >= win_lo) && (BIDX < win_hi);

      can_filt_bank u_bank (
        .key   (key),
        .cfg   (cfg),
        .match (bank_match[b])
      );

      assign qualified[b] = bank_match[b] & cfg_active[b] & in_win;
    end
  endgenerate

  can_filt_prio #(.N(NUM_BANKS)) u_prio (
    .req   (qualified),
    .found (any_hit),
    .idx   (win_idx)
  );

  always_comb begin
    valid_d = hdr_valid;
    hit_d   = res_hit;
    fifo_d  = res_fifo;
    bank_d  = res_bank;
    if (hdr_valid) begin
      hit_d  = any_hit;
      fifo_d = any_hit ? cfg_fifo[win_idx] : 1'b0;
      bank_d = any_hit ? win_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fifo  <= 1'b0;
      res_bank  <= '0;
    end else begin
      res_valid <= valid_d;
      if (hdr_valid) begin
        res_hit  <= hit_d;
        res_fifo <= fifo_d;
        res_bank <= bank_d;
      end
    end
  end
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
  parameter int  NUM_BANKS = 28,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hdr_valid,
  input logic [NUM_BANKS-1:0] cfg_fifo,
  input logic [NUM_BANKS-1:0] cfg_active,
  input logic [CNT_W-1:0]     range_start,
  input logic [CNT_W-1:0]     range_count,
  input logic                 res_valid,
  input logic                 res_hit,
  input logic                 res_fifo,
  input logic [IDX_W-1:0]     res_bank
);
  logic [NUM_BANKS-1:0] act_q;
  logic [NUM_BANKS-1:0] fifo_q;
  logic [CNT_W:0]       lo_q;
  logic [CNT_W:0]       hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      fifo_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      act_q  <= cfg_active;
      fifo_q <= cfg_fifo;
      lo_q   <= {1'b0, range_start};
      hi_q   <= {1'b0, range_start} + {1'b0, range_count};
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_valid);
  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(res_hit) && $stable(res_fifo) && $stable(res_bank)));
  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_bank == '0 && !res_fifo));
  // R9
  active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> act_q[res_bank]);
  // R10
  fifo_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_fifo == fifo_q[res_bank]));
  // R11
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (({1'b0, res_bank} >= lo_q) && ({1'b0, res_bank} < hi_q)));
endmodule

bind can_accept_filter can_filt_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_valid   (hdr_valid),
  .cfg_fifo    (cfg_fifo),
  .cfg_active  (cfg_active),
  .range_start (range_start),
  .range_count (range_count),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_fifo    (res_fifo),
  .res_bank    (res_bank)
);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  localparam int NB    = 28;
  localparam int IDX_W = 5;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              hdr_valid = 1'b0;
  logic [28:0]       hdr_id = '0;
  logic              hdr_ide = 1'b0;
  logic              hdr_rtr = 1'b0;
  logic [31:0]       bw1 [NB];
  logic [31:0]       bw2 [NB];
  logic [NB-1:0]     b_list, b_wide, b_fifo, b_act;
  logic [CNT_W-1:0]  r_start, r_count;
  logic [NB*32-1:0]  w1_flat, w2_flat;
  logic              res_valid, res_hit, res_fifo;
  logic [IDX_W-1:0]  res_bank;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      w1_flat[i*32 +: 32] = bw1[i];
      w2_flat[i*32 +: 32] = bw2[i];
    end
  end

  can_accept_filter #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr), .cfg_word1(w1_flat), .cfg_word2(w2_flat),
    .cfg_list(b_list), .cfg_wide(b_wide), .cfg_fifo(b_fifo), .cfg_active(b_act),
    .range_start(r_start), .range_count(r_count),
    .res_valid(res_valid), .res_hit(res_hit), .res_fifo(res_fifo), .res_bank(res_bank)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R12";

  // behavioural reference
  function automatic void ref_eval(input logic [28:0] id, input bit ide, input bit rtr,
                                   output bit hit, output bit fifo, output int bank);
    longint unsigned k32, k16, e, w, idv, m;
    bit ok;
    hit = 0; fifo = 0; bank = 0;
    if (ide) k32 = longint'(id) * 8 + 4 + rtr * 2;
    else     k32 = (longint'(id) % 2048) * (1 << 21) + rtr * 2;
    k16 = ((k32 >> 16) & 'hFFE0) + rtr * 16 + ide * 8 + ((k32 >> 18) & 7);
    for (int i = 0; i < NB; i++) begin
      if (!b_act[i] || i < int'(r_start) || i >= int'(r_start) + int'(r_count)) continue;
      ok = 0;
      if (b_wide[i]) begin
        if (b_list[i]) ok = (k32 == bw1[i]) || (k32 == bw2[i]);
        else ok = ((k32 & bw2[i]) == (bw1[i] & bw2[i]));
      end else begin
        for (int s = 0; s < 4; s++) begin
          w = (s < 2) ? bw1[i] : bw2[i];
          if (b_list[i]) begin
            e = (s % 2) ? (w >> 16) : (w & 'hFFFF);
            if (e == k16) ok = 1;
          end else if (s < 2) begin
            w = s ? bw2[i] : bw1[i];
            idv = w & 'hFFFF; m = w >> 16;
            if ((k16 & m) == (idv & m)) ok = 1;
          end
        end
      end
      if (ok) begin hit = 1; fifo = b_fifo[i]; bank = i; return; end
    end
  endfunction

  bit e_valid, e_hit, e_fifo;
  int e_bank;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 0; e_hit <= 0; e_fifo <= 0; e_bank <= 0;
    end else begin
      e_valid <= hdr_valid;
      if (hdr_valid) begin
        bit h, f; int bk;
        ref_eval(hdr_id, hdr_ide, hdr_rtr, h, f, bk);
        e_hit <= h; e_fifo <= f; e_bank <= bk;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (res_valid !== e_valid || res_hit !== e_hit || res_fifo !== e_fifo ||
          int'(res_bank) != e_bank) begin
        bad++;
        $display("FAIL %s: got valid=%0b hit=%0b fifo=%0b bank=%0d exp valid=%0b hit=%0b fifo=%0b bank=%0d",
                 cur_req, res_valid, res_hit, res_fifo, res_bank, e_valid, e_hit, e_fifo, e_bank);
      end
    end
  end

  task automatic clear_cfg();
    for (int i = 0; i < NB; i++) begin bw1[i] = '0; bw2[i] = '0; end
    b_list = '0; b_wide = '0; b_fifo = '0; b_act = '0;
    r_start = '0; r_count = CNT_W'(NB);
  endtask

  task automatic send(input logic [28:0] id, input bit ide, input bit rtr);
    @(negedge clk);
    hdr_id = id; hdr_ide = ide; hdr_rtr = rtr; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    hdr_id = ~id;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL R1: watchdog expired, got no finish exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    cur_req = "R12";
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R2 R8: two exact 32-bit entries in bank 3
    clear_cfg(); cur_req = "R4";
    bw1[3] = 32'h123 << 21;
    bw2[3] = (32'h1ABCDEF << 3) | 32'h6;
    b_list[3] = 1; b_wide[3] = 1; b_fifo[3] = 1; b_act[3] = 1;
    send(29'h123, 0, 0);
    send(29'h123, 0, 1);
    send(29'h1ABCDEF, 1, 1);
    cur_req = "R2";
    send(29'h1ABCDEF, 1, 0);
    send(29'h123, 1, 0);
    send(29'h1ABCDEF, 0, 1);

    // R5: 32-bit id/mask in bank 5
    clear_cfg(); cur_req = "R5";
    bw1[5] = (32'h1234500 << 3) | 32'h4;
    bw2[5] = (32'h1FFFFF00 << 3) | 32'h4;
    b_act[5] = 1; b_wide[5] = 1;
    send(29'h12345AB, 1, 0);
    send(29'h12345AB, 1, 1);
    send(29'h12346AB, 1, 0);
    send(29'h500, 0, 0);
    bw1[5] = 32'hDEADBEEF; bw2[5] = '0;
    send(29'h7, 0, 1);
    send(29'h1FFFFFFF, 1, 0);

    // R6 R8: four exact 16-bit entries in bank 7
    clear_cfg(); cur_req = "R6";
    bw1[7] = 32'h0400_0200;
    bw2[7] = 32'h0810_0600;
    b_act[7] = 1; b_list[7] = 1; b_fifo[7] = 1;
    send(29'h10, 0, 0);
    send(29'h20, 0, 0);
    send(29'h30, 0, 0);
    send(29'h40, 0, 1);
    send(29'h40, 0, 0);
    send(29'h10, 0, 1);

    // R7 R3: two 16-bit id/mask pairs in bank 9
    clear_cfg(); cur_req = "R7";
    bw1[9] = 32'h000F_000D;
    bw2[9] = 32'hFFE8_0AA0;
    b_act[9] = 1;
    send(29'h55, 0, 0);
    send(29'h55, 0, 1);
    send(29'h55, 1, 0);
    cur_req = "R3";
    send(29'h0028000, 1, 0);
    send(29'h1FEA8000, 1, 1);
    send(29'h0020000, 1, 0);
    send(29'h0030000, 1, 0);

    // R10 R9: overlapping accept-all banks
    clear_cfg(); cur_req = "R10";
    b_act[2] = 1; b_act[6] = 1; b_wide[2] = 1; b_fifo[6] = 1;
    send(29'h3A5, 0, 0);
    send(29'h1234567, 1, 1);
    cur_req = "R9";
    b_act[2] = 0;
    send(29'h3A5, 0, 0);
    b_act[6] = 0;
    send(29'h3A5, 0, 0);

    // R11: controller window
    clear_cfg(); cur_req = "R11";
    b_act[2] = 1; b_act[6] = 1; b_act[27] = 1; b_fifo[2] = 1;
    r_start = 4; r_count = 3;
    send(29'h11, 0, 0);
    r_count = 2;
    send(29'h11, 0, 0);
    r_start = 27; r_count = 1;
    send(29'h11, 0, 0);
    r_start = 0; r_count = 2;
    send(29'h11, 0, 0);

    // R1 R8: random configurations and back-to-back headers
    cur_req = "R1";
    for (int rnd = 0; rnd < 40; rnd++) begin
      for (int i = 0; i < NB; i++) begin
        bw1[i] = $urandom;
        bw2[i] = $urandom & $urandom & $urandom;
      end
      b_list = NB'($urandom); b_wide = NB'($urandom);
      b_fifo = NB'($urandom); b_act = NB'($urandom) & NB'($urandom);
      r_start = CNT_W'($urandom % 10); r_count = CNT_W'($urandom % 19);
      for (int f = 0; f < 30; f++) begin
        @(negedge clk);
        hdr_valid = ($urandom % 3) != 0;
        hdr_id = 29'($urandom);
        hdr_ide = 1'($urandom); hdr_rtr = 1'($urandom);
      end
      @(negedge clk);
      hdr_valid = 1'b0;
      @(negedge clk);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule